// File: doc/BRIEF.md
# Parallel NOR Flash Command Interpreter with Erase Suspend

This block is a clocked model of the command front end of a 16-bit parallel NOR flash. It watches single-cycle write strobes carrying an address and a data word. It decodes unlock-prefixed command sequences for word program, sector erase, block erase and chip erase. An accepted operation runs for a parameterised number of clock cycles. While it runs, reads return a status word instead of array contents. A small register file, initialised to the erased value, stands in for the cell array.

A sector or block erase can be suspended with a single write. After a parameterised latency the block becomes ready again. Reads of the sectors under erase then return a suspend status. Reads of all other sectors return array data, and word program is accepted everywhere except the suspended sectors. A single resume write continues the erase where it stopped. A write-protect input, active low, blocks chip erase and any erase aimed at the lowest block.

Top module: `nor_cmd_engine`

## Requirements
- R1: After reset `busy_o` is 0 and `rdata_o` is 0. Every array word reads 16'hFFFF.
- R2: Word program is the write sequence (16'h..AA @ 11'h555), (16'h..55 @ 11'h2AA), (16'h..A0 @ 11'h555), then (data @ target). Only data bits [7:0] are decoded in command cycles. `busy_o` is high for exactly PROG_CYC cycles, starting the cycle after the target write. After that the target word reads the data. The array index is address bits [5:0].
- R3: While a sector, block or chip erase is running, every write other than a suspend write is ignored. This includes complete program sequences.
- R4: While `wp_ni` is 0, a chip erase is ignored. A sector or block erase whose address bit [5] is 0 (block 0) is also ignored. `busy_o` stays 0 and the array is unchanged.
- R5: An erase sequence is (AA@555), (55@2AA), (80@555), (AA@555), (55@2AA) followed by a sixth write. Data 8'h30 at any address in the sixth write erases the 8-word sector given by address bits [5:3]. Data 8'h50 in the sixth write erases the 32-word block given by bit [5]. `busy_o` is high for ERASE_CYC cycles, then the target words read 16'hFFFF and all other words are unchanged. During the erase, reads return 16'h0000 except bit 6 and bit 2, and both of these toggle.
- R6: A sixth write of 8'h10 @ 11'h555 starts a chip erase. `busy_o` is high for CHIP_CYC cycles, and then every word reads 16'hFFFF.
- R7: A write of 8'hB0 during a sector or block erase suspends it. `busy_o` stays high for SUSP_LAT more cycles and then falls. A write of 8'hB0 during a chip erase is ignored.
- R8: While suspended, a read inside a suspended sector returns bit 6 = 1, a bit 2 that toggles on each such read, and all other bits 0. A read elsewhere returns array data.
- R9: While suspended, a word program outside the suspended sectors runs for PROG_CYC cycles and then lands in the array. A word program inside the suspended sectors is ignored.
- R10: While suspended, a write of 8'h30 at any address, outside any partial sequence, resumes the erase. `busy_o` then stays high for the erase cycles that were still left.
- R11: A write that does not match the next expected cycle of a sequence returns the interpreter to idle.
- R12: A read returning a toggling bit 6 outputs the bit's current value and then inverts it. Bit 2 follows the same rule. Each bit starts at 0 after reset. During a program, status bit 7 is the inverse of data bit 7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Write strobe, one cycle per write |
| re_i | input | 1 | Read strobe; data appears on `rdata_o` the next cycle |
| addr_i | input | ADDR_W | Word address for reads and writes |
| wdata_i | input | DATA_W | Write data |
| wp_ni | input | 1 | Write protect, active low |
| rdata_o | output | DATA_W | Registered read data or status word |
| busy_o | output | 1 | Internal operation in progress |

## Verification
Program sequences are run with clean timing and with one address corrupted. This separates the unlock decoder's restart from normal acceptance. Sector, block and chip erases are run with `wp_ni` both high and low, and with program and suspend writes injected mid-erase. These runs separate the ignore rules for running erases, protected targets and the chip-erase suspend exemption. The suspend scenario reads inside and outside the suspended sector and programs both kinds of address. It then resumes, so the per-sector status, the leftover erase time and the preserved array contents are each observed at the ports.

// File: rtl/nor_cmd_pkg.sv
package nor_cmd_pkg;

  typedef enum logic [2:0] {
    M_IDLE, M_PROG, M_ERASE, M_SPEND, M_SUSP, M_SPROG
  } mode_e;

  typedef enum logic [2:0] {
    C_NONE, C_PROG, C_SECT, C_BLOCK, C_CHIP
  } cmd_e;

  localparam logic [7:0] K_UNLK1  = 8'hAA;
  localparam logic [7:0] K_UNLK2  = 8'h55;
  localparam logic [7:0] K_PROG   = 8'hA0;
  localparam logic [7:0] K_ERASE  = 8'h80;
  localparam logic [7:0] K_CHIP   = 8'h10;
  localparam logic [7:0] K_SECT   = 8'h30;
  localparam logic [7:0] K_BLOCK  = 8'h50;
  localparam logic [7:0] K_SUSP   = 8'hB0;
  localparam logic [7:0] K_RESUME = 8'h30;

  localparam logic [10:0] A_FIRST  = 11'h555;
  localparam logic [10:0] A_SECOND = 11'h2AA;

  function automatic int unsigned max_u(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
  import nor_cmd_pkg::*;
#(
  parameter int unsigned ADDR_W = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        data_i,
  output cmd_e              cmd_o,
  output logic              idle_o
);

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_U1, SQ_U2, SQ_PADR, SQ_E3, SQ_E4, SQ_E5
  } sq_e;

  localparam logic [ADDR_W-1:0] ADR1 = ADDR_W'(A_FIRST);
  localparam logic [ADDR_W-1:0] ADR2 = ADDR_W'(A_SECOND);

  sq_e  st_q, st_d;
  logic at1, at2;

  assign at1    = (addr_i == ADR1);
  assign at2    = (addr_i == ADR2);
  assign idle_o = (st_q == SQ_IDLE);

  always_comb begin
    st_d  = st_q;
    cmd_o = C_NONE;
    if (!en_i) begin
      st_d = SQ_IDLE;
    end else if (we_i) begin
      st_d = SQ_IDLE;
      unique case (st_q)
        SQ_IDLE: if (at1 && data_i == K_UNLK1) st_d = SQ_U1;
        SQ_U1:   if (at2 && data_i == K_UNLK2) st_d = SQ_U2;
        SQ_U2: begin
          if (at1 && data_i == K_PROG)       st_d = SQ_PADR;
          else if (at1 && data_i == K_ERASE) st_d = SQ_E3;
        end
        SQ_PADR: cmd_o = C_PROG;
        SQ_E3:   if (at1 && data_i == K_UNLK1) st_d = SQ_E4;
        SQ_E4:   if (at2 && data_i == K_UNLK2) st_d = SQ_E5;
        SQ_E5: begin
          if (at1 && data_i == K_CHIP)  cmd_o = C_CHIP;
          else if (data_i == K_SECT)    cmd_o = C_SECT;
          else if (data_i == K_BLOCK)   cmd_o = C_BLOCK;
        end
        default: st_d = SQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= SQ_IDLE;
    else         st_q <= st_d;
  end

endmodule

// File: rtl/nor_cmd_ctrl.sv
module nor_cmd_ctrl
  import nor_cmd_pkg::*;
#(
  parameter int unsigned ARR_W     = 6,
  parameter int unsigned SECT_W    = 3,
  parameter int unsigned BLK_W     = 5,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned PROG_CYC  = 8,
  parameter int unsigned ERASE_CYC = 200,
  parameter int unsigned CHIP_CYC  = 400,
  parameter int unsigned SUSP_LAT  = 20,
  localparam int unsigned NSECT    = 1 << (ARR_W - SECT_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ARR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              wp_ni,
  input  cmd_e              cmd_i,
  input  logic              seq_idle_i,
  output mode_e             mode_o,
  output logic              seq_en_o,
  output logic              busy_o,
  output logic [NSECT-1:0]  mask_o,
  output logic              pg_we_o,
  output logic [ARR_W-1:0]  pg_addr_o,
  output logic [DATA_W-1:0] pg_data_o,
  output logic              er_o
);

  localparam int unsigned SIDX_W  = ARR_W - SECT_W;
  localparam int unsigned BIDX_W  = ARR_W - BLK_W;
  localparam int unsigned SPB_SH  = BLK_W - SECT_W;
  localparam int unsigned CNT_MAX = max_u(max_u(PROG_CYC, ERASE_CYC),
                                          max_u(CHIP_CYC, SUSP_LAT));
  localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);

  localparam logic [CNT_W-1:0] PROG_LD  = CNT_W'(PROG_CYC - 1);
  localparam logic [CNT_W-1:0] ERASE_LD = CNT_W'(ERASE_CYC - 1);
  localparam logic [CNT_W-1:0] CHIP_LD  = CNT_W'(CHIP_CYC - 1);
  localparam logic [CNT_W-1:0] SUSP_LD  = CNT_W'(SUSP_LAT - 1);

  mode_e              mode_q;
  logic [CNT_W-1:0]   ecnt_q, acnt_q;
  logic [NSECT-1:0]   mask_q, sect_mask, blk_mask;
  logic               chip_q;
  logic [ARR_W-1:0]   paddr_q;
  logic [DATA_W-1:0]  pdata_q;
  logic [SIDX_W-1:0]  csec;
  logic [BIDX_W-1:0]  cblk;
  logic               prot, susp_hit, res_hit, acnt_done;

  assign csec      = addr_i[ARR_W-1:SECT_W];
  assign cblk      = addr_i[ARR_W-1:BLK_W];
  assign prot      = (cblk == '0);
  assign susp_hit  = we_i && (wdata_i[7:0] == K_SUSP) && !chip_q;
  assign res_hit   = we_i && seq_idle_i && (wdata_i[7:0] == K_RESUME);
  assign acnt_done = (acnt_q == '0);

  always_comb begin
    sect_mask       = '0;
    sect_mask[csec] = 1'b1;
    for (int s = 0; s < NSECT; s++) begin
      blk_mask[s] = ((s >> SPB_SH) == int'(cblk));
    end
  end

  assign mode_o    = mode_q;
  assign mask_o    = mask_q;
  assign pg_addr_o = paddr_q;
  assign pg_data_o = pdata_q;
  assign seq_en_o  = (mode_q == M_IDLE) || (mode_q == M_SUSP);
  assign busy_o    = (mode_q == M_PROG) || (mode_q == M_ERASE) ||
                     (mode_q == M_SPEND) || (mode_q == M_SPROG);
  assign pg_we_o   = ((mode_q == M_PROG) || (mode_q == M_SPROG)) && acnt_done;
  assign er_o      = (mode_q == M_ERASE) && !susp_hit && (ecnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= M_IDLE;
      ecnt_q  <= '0;
      acnt_q  <= '0;
      mask_q  <= '0;
      chip_q  <= 1'b0;
      paddr_q <= '0;
      pdata_q <= '0;
    end else begin
      unique case (mode_q)
        M_IDLE: begin
          unique case (cmd_i)
            C_PROG: begin
              mode_q  <= M_PROG;
              acnt_q  <= PROG_LD;
              paddr_q <= addr_i;
              pdata_q <= wdata_i;
            end
            C_SECT: if (wp_ni || !prot) begin
              mode_q <= M_ERASE;
              ecnt_q <= ERASE_LD;
              mask_q <= sect_mask;
              chip_q <= 1'b0;
            end
            C_BLOCK: if (wp_ni || !prot) begin
              mode_q <= M_ERASE;
              ecnt_q <= ERASE_LD;
              mask_q <= blk_mask;
              chip_q <= 1'b0;
            end
            C_CHIP: if (wp_ni) begin
              mode_q <= M_ERASE;
              ecnt_q <= CHIP_LD;
              mask_q <= '1;
              chip_q <= 1'b1;
            end
            default: ;
          endcase
        end
        M_PROG, M_SPROG: begin
          if (acnt_done) mode_q <= (mode_q == M_SPROG) ? M_SUSP : M_IDLE;
          else           acnt_q <= acnt_q - 1'b1;
        end
        M_ERASE: begin
          if (susp_hit) begin
            mode_q <= M_SPEND;
            acnt_q <= SUSP_LD;
          end else if (ecnt_q == '0) begin
            mode_q <= M_IDLE;
            mask_q <= '0;
            chip_q <= 1'b0;
          end else begin
            ecnt_q <= ecnt_q - 1'b1;
          end
        end
        M_SPEND: begin
          if (acnt_done) mode_q <= M_SUSP;
          else           acnt_q <= acnt_q - 1'b1;
        end
        M_SUSP: begin
          if (res_hit) begin
            mode_q <= M_ERASE;
          end else if (cmd_i == C_PROG && !mask_q[csec]) begin
            mode_q  <= M_SPROG;
            acnt_q  <= PROG_LD;
            paddr_q <= addr_i;
            pdata_q <= wdata_i;
          end
        end
        default: mode_q <= M_IDLE;
      endcase
    end
  end

  AST_ERASE_IGNORES_CMD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == M_ERASE && ecnt_q != '0 && we_i && wdata_i[7:0] != K_SUSP)
      |=> (mode_q == M_ERASE && $stable(mask_q))); // R3

  AST_WP_BLOCKS_CHIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == M_IDLE && cmd_i == C_CHIP && !wp_ni) |=> (mode_q == M_IDLE)); // R4

  AST_CHIP_NO_SUSPEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == M_ERASE && chip_q) |=> (mode_q != M_SPEND)); // R7

  AST_SUSP_HOLDS_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == M_SUSP && $past(mode_q) == M_SUSP) |-> $stable(mask_q)); // R8

  AST_SPROG_OUTSIDE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == M_SPROG) |-> !mask_q[paddr_q[ARR_W-1:SECT_W]]); // R9

endmodule

// File: rtl/nor_cmd_array.sv
module nor_cmd_array
  import nor_cmd_pkg::*;
#(
  parameter int unsigned ARR_W  = 6,
  parameter int unsigned SECT_W = 3,
  parameter int unsigned DATA_W = 16,
  localparam int unsigned NSECT = 1 << (ARR_W - SECT_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              re_i,
  input  logic [ARR_W-1:0]  raddr_i,
  input  mode_e             mode_i,
  input  logic [NSECT-1:0]  mask_i,
  input  logic              pg_we_i,
  input  logic [ARR_W-1:0]  pg_addr_i,
  input  logic [DATA_W-1:0] pg_data_i,
  input  logic              er_i,
  output logic [DATA_W-1:0] rdata_o
);

  localparam int unsigned WORDS  = 1 << ARR_W;
  localparam int unsigned SIDX_W = ARR_W - SECT_W;

  logic [DATA_W-1:0] mem_q [WORDS];
  logic [SIDX_W-1:0] rsec;
  logic              tog6_q, tog2_q;
  logic              in_susp;

  assign rsec    = raddr_i[ARR_W-1:SECT_W];
  assign in_susp = (mode_i == M_SUSP) && mask_i[rsec];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int w = 0; w < WORDS; w++) mem_q[w] <= '1;
    end else begin
      for (int w = 0; w < WORDS; w++) begin
        if (pg_we_i && pg_addr_i == ARR_W'(w))  mem_q[w] <= pg_data_i;
        else if (er_i && mask_i[w >> SECT_W])   mem_q[w] <= '1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o <= '0;
      tog6_q  <= 1'b0;
      tog2_q  <= 1'b0;
    end else if (re_i) begin
      rdata_o <= '0;
      unique case (mode_i)
        M_PROG, M_SPROG: begin
          rdata_o[7] <= ~pg_data_i[7];
          rdata_o[6] <= tog6_q;
          tog6_q     <= ~tog6_q;
        end
        M_ERASE, M_SPEND: begin
          rdata_o[6] <= tog6_q;
          rdata_o[2] <= tog2_q;
          tog6_q     <= ~tog6_q;
          tog2_q     <= ~tog2_q;
        end
        default: begin
          if (in_susp) begin
            rdata_o[6] <= 1'b1;
            rdata_o[2] <= tog2_q;
            tog2_q     <= ~tog2_q;
          end else begin
            rdata_o <= mem_q[raddr_i];
          end
        end
      endcase
    end
  end

  AST_SUSP_READ_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && in_susp) |=> (rdata_o[6] && rdata_o[DATA_W-1:7] == '0)); // R8

  AST_SUSP_TOGGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && in_susp && $past(re_i && in_susp)) |=> (rdata_o[2] != $past(rdata_o[2]))); // R12

endmodule

// File: rtl/nor_cmd_engine.sv
module nor_cmd_engine
  import nor_cmd_pkg::*;
#(
  parameter int unsigned ADDR_W    = 11,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned ARR_W     = 6,
  parameter int unsigned SECT_W    = 3,
  parameter int unsigned BLK_W     = 5,
  parameter int unsigned PROG_CYC  = 8,
  parameter int unsigned ERASE_CYC = 200,
  parameter int unsigned CHIP_CYC  = 400,
  parameter int unsigned SUSP_LAT  = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              re_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              wp_ni,
  output logic [DATA_W-1:0] rdata_o,
  output logic              busy_o
);

  localparam int unsigned NSECT = 1 << (ARR_W - SECT_W);

  cmd_e              cmd;
  mode_e             mode;
  logic              seq_idle, seq_en, pg_we, er;
  logic [NSECT-1:0]  mask;
  logic [ARR_W-1:0]  pg_addr;
  logic [DATA_W-1:0] pg_data;

  nor_cmd_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (seq_en),
    .we_i   (we_i),
    .addr_i (addr_i),
    .data_i (wdata_i[7:0]),
    .cmd_o  (cmd),
    .idle_o (seq_idle)
  );

  nor_cmd_ctrl #(
    .ARR_W(ARR_W), .SECT_W(SECT_W), .BLK_W(BLK_W), .DATA_W(DATA_W),
    .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC),
    .CHIP_CYC(CHIP_CYC), .SUSP_LAT(SUSP_LAT)
  ) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (we_i),
    .addr_i     (addr_i[ARR_W-1:0]),
    .wdata_i    (wdata_i),
    .wp_ni      (wp_ni),
    .cmd_i      (cmd),
    .seq_idle_i (seq_idle),
    .mode_o     (mode),
    .seq_en_o   (seq_en),
    .busy_o     (busy_o),
    .mask_o     (mask),
    .pg_we_o    (pg_we),
    .pg_addr_o  (pg_addr),
    .pg_data_o  (pg_data),
    .er_o       (er)
  );

  nor_cmd_array #(.ARR_W(ARR_W), .SECT_W(SECT_W), .DATA_W(DATA_W)) u_array (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .re_i      (re_i),
    .raddr_i   (addr_i[ARR_W-1:0]),
    .mode_i    (mode),
    .mask_i    (mask),
    .pg_we_i   (pg_we),
    .pg_addr_i (pg_addr),
    .pg_data_i (pg_data),
    .er_i      (er),
    .rdata_o   (rdata_o)
  );

endmodule

// File: tb/nor_cmd_engine_bench.sv
`timescale 1ns/1ps
module nor_cmd_engine_bench;

  localparam int PROG_CYC  = 8;
  localparam int ERASE_CYC = 60;
  localparam int CHIP_CYC  = 90;
  localparam int SUSP_LAT  = 12;

  localparam int MI = 0, MP = 1, ME = 2, MSP = 3, MS = 4, MSG = 5;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        we_i = 1'b0, re_i = 1'b0, wp_ni = 1'b1;
  logic [10:0] addr_i = '0;
  logic [15:0] wdata_i = '0;
  logic [15:0] rdata_o;
  logic        busy_o;

  always #10 clk_i = ~clk_i;

  nor_cmd_engine #(
    .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC),
    .CHIP_CYC(CHIP_CYC), .SUSP_LAT(SUSP_LAT)
  ) u_nor_cmd_engine (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_i), .re_i(re_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .wp_ni(wp_ni),
    .rdata_o(rdata_o), .busy_o(busy_o)
  );

  int    checks = 0, errors = 0;
  string cur_req = "R1";
  bit    done = 0;

  // reference model state
  logic [15:0] m_mem [64];
  int          m_mode = MI, m_sq = 0, m_e = 0, m_a = 0;
  logic [7:0]  m_mask = '0;
  bit          m_chip = 0, m_t6 = 0, m_t2 = 0;
  logic [5:0]  m_paddr = '0;
  logic [15:0] m_pdata = '0, m_rd = '0;

  function automatic bit m_busy();
    return m_mode == MP || m_mode == ME || m_mode == MSP || m_mode == MSG;
  endfunction

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      for (int w = 0; w < 64; w++) m_mem[w] = 16'hFFFF;
      m_mode = MI; m_sq = 0; m_e = 0; m_a = 0; m_mask = '0; m_chip = 0;
      m_t6 = 0; m_t2 = 0; m_rd = '0; m_paddr = '0; m_pdata = '0;
    end else begin
      int cmd;
      bit res;
      logic [7:0] lo;
      cmd = 0; res = 0; lo = wdata_i[7:0];
      if (re_i) begin
        if (m_mode == MP || m_mode == MSG) begin
          m_rd = 16'h0; m_rd[7] = ~m_pdata[7]; m_rd[6] = m_t6; m_t6 = ~m_t6;
        end else if (m_mode == ME || m_mode == MSP) begin
          m_rd = 16'h0; m_rd[6] = m_t6; m_rd[2] = m_t2; m_t6 = ~m_t6; m_t2 = ~m_t2;
        end else if (m_mode == MS && m_mask[addr_i[5:3]]) begin
          m_rd = 16'h0040; m_rd[2] = m_t2; m_t2 = ~m_t2;
        end else m_rd = m_mem[addr_i[5:0]];
      end
      if (m_mode == MI || m_mode == MS) begin
        if (we_i) begin
          if (m_mode == MS && m_sq == 0 && lo == 8'h30) res = 1;
          case (m_sq)
            0: m_sq = (lo == 8'hAA && addr_i == 11'h555) ? 1 : 0;
            1: m_sq = (lo == 8'h55 && addr_i == 11'h2AA) ? 2 : 0;
            2: m_sq = (addr_i != 11'h555) ? 0 : (lo == 8'hA0) ? 3 : (lo == 8'h80) ? 4 : 0;
            3: begin cmd = 1; m_sq = 0; end
            4: m_sq = (lo == 8'hAA && addr_i == 11'h555) ? 5 : 0;
            5: m_sq = (lo == 8'h55 && addr_i == 11'h2AA) ? 6 : 0;
            default: begin
              if (lo == 8'h10 && addr_i == 11'h555) cmd = 4;
              else if (lo == 8'h30) cmd = 2;
              else if (lo == 8'h50) cmd = 3;
              m_sq = 0;
            end
          endcase
        end
      end else m_sq = 0;
      case (m_mode)
        MI: begin
          if (cmd == 1) begin
            m_mode = MP; m_a = PROG_CYC - 1; m_paddr = addr_i[5:0]; m_pdata = wdata_i;
          end else if ((cmd == 2 || cmd == 3) && (wp_ni || addr_i[5])) begin
            m_mode = ME; m_e = ERASE_CYC - 1; m_chip = 0;
            if (cmd == 2) m_mask = 8'(1 << addr_i[5:3]);
            else          m_mask = addr_i[5] ? 8'hF0 : 8'h0F;
          end else if (cmd == 4 && wp_ni) begin
            m_mode = ME; m_e = CHIP_CYC - 1; m_chip = 1; m_mask = 8'hFF;
          end
        end
        MP, MSG: begin
          if (m_a == 0) begin
            m_mem[m_paddr] = m_pdata; m_mode = (m_mode == MSG) ? MS : MI;
          end else m_a--;
        end
        ME: begin
          if (we_i && lo == 8'hB0 && !m_chip) begin
            m_mode = MSP; m_a = SUSP_LAT - 1;
          end else if (m_e == 0) begin
            for (int w = 0; w < 64; w++) if (m_mask[w/8]) m_mem[w] = 16'hFFFF;
            m_mask = '0; m_chip = 0; m_mode = MI;
          end else m_e--;
        end
        MSP: if (m_a == 0) m_mode = MS; else m_a--;
        default: begin
          if (res) m_mode = ME;
          else if (cmd == 1 && !m_mask[addr_i[5:3]]) begin
            m_mode = MSG; m_a = PROG_CYC - 1; m_paddr = addr_i[5:0]; m_pdata = wdata_i;
          end
        end
      endcase
    end
  end

  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      checks++;
      if (busy_o !== m_busy()) begin
        errors++;
        $display("FAIL %s busy_o actual %0b expected %0b at %0t", cur_req, busy_o, m_busy(), $time);
      end
      checks++;
      if (rdata_o !== m_rd) begin
        errors++;
        $display("FAIL %s rdata_o actual %h expected %h at %0t", cur_req, rdata_o, m_rd, $time);
      end
    end
  end

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [10:0] a, input logic [15:0] d);
    @(negedge clk_i); we_i = 1; addr_i = a; wdata_i = d;
    @(negedge clk_i); we_i = 0;
  endtask

  task automatic rd(input logic [10:0] a, output logic [15:0] d);
    @(negedge clk_i); re_i = 1; addr_i = a;
    @(negedge clk_i); re_i = 0; d = rdata_o;
  endtask

  task automatic prog(input logic [10:0] a, input logic [15:0] d);
    wr(11'h555, 16'h00AA); wr(11'h2AA, 16'h0055); wr(11'h555, 16'h00A0); wr(a, d);
  endtask

  task automatic erase6(input logic [10:0] a, input logic [15:0] d);
    wr(11'h555, 16'h00AA); wr(11'h2AA, 16'h0055); wr(11'h555, 16'h0080);
    wr(11'h555, 16'h00AA); wr(11'h2AA, 16'h0055); wr(a, d);
  endtask

  task automatic count_busy(output int n);
    n = 0;
    while (busy_o) begin n++; @(negedge clk_i); end
  endtask

  task automatic finish_run();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog actual hung expected finished");
    finish_run();
  end

  initial begin
    logic [15:0] d, d2;
    int n;
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    cur_req = "R1";
    chk("R1 busy", {15'b0, busy_o}, 16'h0);
    chk("R1 rdata", rdata_o, 16'h0);
    rd(11'h005, d); chk("R1 erased", d, 16'hFFFF);

    cur_req = "R2";
    prog(11'h005, 16'h1234);
    rd(11'h005, d); chk("R2 status hi", {d[15:7], 7'b0}, 16'h0080);
    rd(11'h005, d2); chk("R12 bit6 toggles", {15'b0, d[6] ^ d2[6]}, 16'h1);
    count_busy(n); rd(11'h005, d); chk("R2 data", d, 16'h1234);
    prog(11'h008, 16'h00C3); count_busy(n);
    chk("R2 busy len", 16'(n), 16'(PROG_CYC));
    rd(11'h008, d); chk("R2 data2", d, 16'h00C3);

    cur_req = "R11";
    wr(11'h555, 16'h00AA); wr(11'h2AB, 16'h0055); wr(11'h555, 16'h00A0);
    wr(11'h007, 16'hBEEF);
    chk("R11 busy", {15'b0, busy_o}, 16'h0);
    rd(11'h007, d); chk("R11 no prog", d, 16'hFFFF);

    prog(11'h028, 16'hAAAA); count_busy(n);
    prog(11'h030, 16'h5555); count_busy(n);
    prog(11'h02C, 16'h1111); count_busy(n);

    cur_req = "R5";
    erase6(11'h009, 16'h0030);
    rd(11'h009, d); rd(11'h009, d2);
    chk("R5 status mask", d & 16'hFFBB, 16'h0);
    chk("R5 toggles", {14'b0, d[6] ^ d2[6], d[2] ^ d2[2]}, 16'h3);
    cur_req = "R3";
    prog(11'h030, 16'h0000);
    count_busy(n);
    rd(11'h030, d); chk("R3 ignored", d, 16'h5555);
    cur_req = "R5";
    rd(11'h008, d); chk("R5 sector erased", d, 16'hFFFF);
    rd(11'h005, d); chk("R5 other kept", d, 16'h1234);

    cur_req = "R4";
    wp_ni = 0;
    erase6(11'h005, 16'h0030); @(negedge clk_i);
    chk("R4 sector busy", {15'b0, busy_o}, 16'h0);
    erase6(11'h555, 16'h0010); @(negedge clk_i);
    chk("R4 chip busy", {15'b0, busy_o}, 16'h0);
    erase6(11'h000, 16'h0050); @(negedge clk_i);
    chk("R4 block busy", {15'b0, busy_o}, 16'h0);
    rd(11'h005, d); chk("R4 kept", d, 16'h1234);
    wp_ni = 1;

    cur_req = "R5";
    erase6(11'h000, 16'h0050); count_busy(n);
    chk("R5 block len", 16'(n), 16'(ERASE_CYC));
    rd(11'h005, d); chk("R5 block erased", d, 16'hFFFF);
    rd(11'h028, d); chk("R5 block1 kept", d, 16'hAAAA);

    cur_req = "R7";
    erase6(11'h02A, 16'h0030);
    repeat (10) @(negedge clk_i);
    wr(11'h123, 16'h00B0); count_busy(n);
    chk("R7 suspend latency", 16'(n), 16'(SUSP_LAT));

    cur_req = "R8";
    rd(11'h029, d); rd(11'h029, d2);
    chk("R8 flags", d & 16'hFFFB, 16'h0040);
    chk("R8 bit2 toggles", {15'b0, d[2] ^ d2[2]}, 16'h1);
    rd(11'h030, d); chk("R8 outside", d, 16'h5555);

    cur_req = "R9";
    prog(11'h031, 16'h0F0F); count_busy(n);
    chk("R9 busy len", 16'(n), 16'(PROG_CYC));
    rd(11'h031, d); chk("R9 data", d, 16'h0F0F);
    prog(11'h02E, 16'h2222); @(negedge clk_i);
    chk("R9 suspended sector", {15'b0, busy_o}, 16'h0);

    cur_req = "R10";
    wr(11'h000, 16'h0030);
    chk("R10 busy", {15'b0, busy_o}, 16'h1);
    count_busy(n);
    rd(11'h028, d); chk("R10 erased", d, 16'hFFFF);
    rd(11'h02C, d); chk("R10 erased2", d, 16'hFFFF);
    rd(11'h030, d); chk("R10 kept", d, 16'h5555);
    rd(11'h031, d); chk("R10 kept2", d, 16'h0F0F);

    cur_req = "R6";
    erase6(11'h555, 16'h0010);
    repeat (5) @(negedge clk_i);
    cur_req = "R7";
    wr(11'h000, 16'h00B0);
    repeat (SUSP_LAT + 2) @(negedge clk_i);
    chk("R7 chip not suspended", {15'b0, busy_o}, 16'h1);
    cur_req = "R6";
    count_busy(n);
    rd(11'h030, d); chk("R6 chip", d, 16'hFFFF);
    rd(11'h031, d); chk("R6 chip2", d, 16'hFFFF);
    rd(11'h008, d); chk("R6 chip3", d, 16'hFFFF);

    repeat (3) @(negedge clk_i);
    finish_run();
  end

endmodule